// File: doc/BRIEF.md
# Bridge control register file

This block is the control and status register bank of a system bridge. It holds 28 words of 32 bits each, reached only as whole words through a word index, where the index is the byte offset divided by four. Most words are plain configuration storage. One word holds interrupt enables and can only be changed through two write aliases, one that sets bits and one that clears them. An enable word and an interrupt status word are read-only. A general configuration word carries a self-reset bit; a write that raises that bit asks the rest of the system for a reset.

Software reaches the bank through a simple request port. A request has a valid strobe, a write flag, a word index and write data. Exactly one clock later, the block returns a response strobe and read data. The reset request leaves the block as a one-cycle pulse. What the stored settings control further down the chip lies outside this block.

Top module: `brg_ctl_regs`

## Requirements
- R1: After reset the words hold these values, and all other words read zero: index 0 = 0x00000C40, index 1 = 0x00001384 (bits 2, 7, 8, 9 and 12 set), index 2 = 0x2BFF8010, index 3 = 0x255E0091, index 4 = 0x00006140, index 7 = 0x000001FF, index 8 = 0x000001FF, index 26 = 0x00000008, index 27 = 0x10000000. The response strobe and the reset request are low after reset.
- R2: A write to a plain word stores the full 32-bit value, and a later read of the same index returns it. The plain words are indices 0 to 11, 16 to 27, and the two alias words 12 and 13. A write response carries read data of zero.
- R3: A write to the set alias (index 12) stores the value in index 12 and ORs it into the enable word (index 14).
- R4: A write to the clear alias (index 13) stores the value in index 13 and clears in the enable word (index 14) every bit that is one in the written value.
- R5: Writes to the enable word (index 14) and to the status word (index 15) have no effect. The status word always reads zero.
- R6: A write to the general configuration word (index 1) whose bit 2 is 1, while the stored bit 2 is 0, raises rst_req_o for exactly one cycle, in the cycle after the write. The written value is still stored.
- R7: rst_req_o stays low for a general configuration write when the stored bit 2 is already 1 or the written bit 2 is 0. It also stays low for every access to any other index and for every read.
- R8: Indices 28 to 31 are unmapped. Writes to them change nothing, and reads of them return zero.
- R9: Every request cycle (req_valid high) is answered by rsp_valid high in the next cycle, and rsp_valid is low in any cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data; zero for writes and unmapped indices |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the request inputs are held quiet while reset is asserted, and that at most one access arrives per cycle. They also assume that the index and data are stable on the rising edge that samples req_valid. The bench drives every input on the falling edge, keeps req_valid low throughout reset, and leaves an idle cycle after every access. Random accesses cover every index from 0 to 31 with random data, so the set, clear and self-reset paths see arbitrary bit patterns. Directed sequences then pin down the read-only words, the unmapped range and the reset-request edge cases.

// File: rtl/brg_ctl_pkg.sv
package brg_ctl_pkg;

   localparam int WORD_W      = 32;
   localparam int IDX_PON     = 0;
   localparam int IDX_GEN     = 1;
   localparam int IDX_IODEV   = 2;
   localparam int IDX_SDRAM   = 3;
   localparam int IDX_MAP     = 4;
   localparam int IDX_GPIO_D  = 7;
   localparam int IDX_GPIO_IE = 8;
   localparam int IDX_EN_SET  = 12;
   localparam int IDX_EN_CLR  = 13;
   localparam int IDX_EN      = 14;
   localparam int IDX_STAT    = 15;
   localparam int IDX_DQ      = 26;
   localparam int IDX_MEMSZ   = 27;

   // bit positions inside the general configuration word
   localparam int GEN_DEBUG    = 0;
   localparam int GEN_SNOOP    = 1;
   localparam int GEN_SELFRST  = 2;
   localparam int GEN_SWAP     = 6;
   localparam int GEN_UNCACHED = 7;
   localparam int GEN_PREFETCH = 8;
   localparam int GEN_WBEHIND  = 9;
   localparam int GEN_QUEUE    = 12;

   typedef enum logic [1:0] {
      KIND_PLAIN,
      KIND_ENABLE,
      KIND_STATUS
   } word_kind_e;

   function automatic logic [WORD_W-1:0] gen_default();
      logic [WORD_W-1:0] v;
      v = '0;
      v[GEN_SELFRST]  = 1'b1;
      v[GEN_UNCACHED] = 1'b1;
      v[GEN_PREFETCH] = 1'b1;
      v[GEN_WBEHIND]  = 1'b1;
      v[GEN_QUEUE]    = 1'b1;
      return v;
   endfunction

   function automatic logic [WORD_W-1:0] reset_value(int idx);
      case (idx)
         IDX_PON:     return 32'h0000_0C40;
         IDX_GEN:     return gen_default();
         IDX_IODEV:   return 32'h2BFF_8010;
         IDX_SDRAM:   return 32'h255E_0091;
         IDX_MAP:     return 32'h0000_6140;
         IDX_GPIO_D:  return 32'h0000_01FF;
         IDX_GPIO_IE: return 32'h0000_01FF;
         IDX_DQ:      return 32'h0000_0008;
         IDX_MEMSZ:   return 32'h1000_0000;
         default:     return '0;
      endcase
   endfunction

   function automatic word_kind_e word_kind(int idx);
      if (idx == IDX_EN)   return KIND_ENABLE;
      if (idx == IDX_STAT) return KIND_STATUS;
      return KIND_PLAIN;
   endfunction

endpackage

// File: rtl/brg_ctl_word.sv
module brg_ctl_word #(
   parameter int              DATA_W  = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/brg_ctl_inten.sv
module brg_ctl_inten #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (set_we) en_q <= en_q | wdata;
      else if (clr_we) en_q <= en_q & ~wdata;
   end

endmodule

// File: rtl/brg_ctl_edge.sv
module brg_ctl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic cur_bit,
   input  logic new_bit,
   output logic pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= we & ~cur_bit & new_bit;
   end

endmodule

// File: rtl/brg_ctl_rdmux.sv
module brg_ctl_rdmux #(
   parameter int DATA_W  = 32,
   parameter int N_WORDS = 28,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] words [N_WORDS],
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N_WORDS; i++) begin
         if (req_addr == ADDR_W'(i)) sel = words[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= (req_valid && !req_write) ? sel : '0;
      end
   end

endmodule

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
   import brg_ctl_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int N_WORDS      = 28,
   parameter int ADDR_W       = 5,
   parameter int SELF_RST_BIT = GEN_SELFRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rst_req_o
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("brg_ctl_regs: DATA_W must match the package word width");
   end
   if (N_WORDS > ADDR_SPAN) begin : g_bad_addr
      $error("brg_ctl_regs: ADDR_W too narrow for N_WORDS");
   end
   if (N_WORDS <= IDX_MEMSZ) begin : g_bad_depth
      $error("brg_ctl_regs: N_WORDS must cover every defined word");
   end
   if (SELF_RST_BIT >= DATA_W) begin : g_bad_bit
      $error("brg_ctl_regs: SELF_RST_BIT out of range");
   end

   logic [N_WORDS-1:0] wr_hit;
   logic [DATA_W-1:0]  words [N_WORDS];
   logic [DATA_W-1:0]  en_q;

   always_comb begin
      for (int i = 0; i < N_WORDS; i++) begin
         wr_hit[i] = req_valid && req_write && (req_addr == ADDR_W'(i));
      end
   end

   for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
      if (word_kind(gi) == KIND_ENABLE) begin : g_en
         assign words[gi] = en_q;
      end else if (word_kind(gi) == KIND_STATUS) begin : g_stat
         assign words[gi] = '0;
      end else begin : g_plain
         brg_ctl_word #(
            .DATA_W  (DATA_W),
            .RST_VAL (reset_value(gi))
         ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_hit[gi]),
            .wdata (req_wdata),
            .q     (words[gi])
         );
      end
   end

   brg_ctl_inten #(.DATA_W(DATA_W)) u_inten (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_hit[IDX_EN_SET]),
      .clr_we (wr_hit[IDX_EN_CLR]),
      .wdata  (req_wdata),
      .en_q   (en_q)
   );

   brg_ctl_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_hit[IDX_GEN]),
      .cur_bit (words[IDX_GEN][SELF_RST_BIT]),
      .new_bit (req_wdata[SELF_RST_BIT]),
      .pulse   (rst_req_o)
   );

   brg_ctl_rdmux #(
      .DATA_W  (DATA_W),
      .N_WORDS (N_WORDS),
      .ADDR_W  (ADDR_W)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .words     (words),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/brg_ctl_chk.sv
module brg_ctl_chk #(
   parameter int DATA_W       = 32,
   parameter int N_WORDS      = 28,
   parameter int ADDR_W       = 5,
   parameter int SELF_RST_BIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rst_req_o,
   input logic [DATA_W-1:0] en_q
);

   localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(12);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(13);

   logic wr_any;
   assign wr_any = req_valid && req_write;

   assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_wr_rdata_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_any |=> (rsp_rdata == '0));
   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (int'(req_addr) >= N_WORDS)) |=> (rsp_rdata == '0));
   assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && req_addr == A_SET) |=> ((en_q & $past(req_wdata)) == $past(req_wdata)));
   assert_clr_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && req_addr == A_CLR) |=> ((en_q & $past(req_wdata)) == '0));
   assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && (req_addr == A_SET || req_addr == A_CLR)) |=> $stable(en_q));
   assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(wr_any && req_addr == A_GEN && req_wdata[SELF_RST_BIT]));
   assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

endmodule

bind brg_ctl_regs brg_ctl_chk #(
   .DATA_W       (DATA_W),
   .N_WORDS      (N_WORDS),
   .ADDR_W       (ADDR_W),
   .SELF_RST_BIT (SELF_RST_BIT)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .rst_req_o (rst_req_o),
   .en_q      (en_q)
);

// File: tb/test_brg_ctl_regs.sv
module test_brg_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rst_req_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] mdl [32];

   always #10 clk = ~clk;

   brg_ctl_regs i_brg_ctl_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rst_req_o (rst_req_o)
   );

   function automatic logic [31:0] dflt(int idx);
      case (idx)
         0:  return 32'h0000_0C40;
         1:  return 32'h0000_1384;
         2:  return 32'h2BFF_8010;
         3:  return 32'h255E_0091;
         4:  return 32'h0000_6140;
         7:  return 32'h0000_01FF;
         8:  return 32'h0000_01FF;
         26: return 32'h0000_0008;
         27: return 32'h1000_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(bit wr, int idx);
      if (idx >= 28) return "R8";
      if (idx == 12) return "R3";
      if (idx == 13) return "R4";
      if (idx == 14 || idx == 15) return "R5";
      if (idx == 1 && wr) return "R6";
      return "R2";
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
      end
   endtask

   // one access: drive at a falling edge, sample at the next falling edge
   task automatic op(input bit wr, input int idx, input logic [31:0] d, input string tovr);
      logic [31:0] exp_rd;
      logic        exp_pulse;
      string       t;
      t = (tovr != "") ? tovr : tag_of(wr, idx);
      exp_rd    = wr ? 32'h0 : mdl[idx];
      exp_pulse = wr && idx == 1 && !mdl[1][2] && d[2];
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 5'(idx); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check(rsp_valid === 1'b1, "R9", {31'b0, rsp_valid}, 32'h1);
      check(rsp_rdata === exp_rd, t, rsp_rdata, exp_rd);
      check(rst_req_o === exp_pulse, exp_pulse ? "R6" : "R7", {31'b0, rst_req_o},
            {31'b0, exp_pulse});
      if (wr) begin
         if (idx == 12) begin
            mdl[12] = d; mdl[14] = mdl[14] | d;
         end else if (idx == 13) begin
            mdl[13] = d; mdl[14] = mdl[14] & ~d;
         end else if (idx < 28 && idx != 14 && idx != 15) begin
            mdl[idx] = d;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 32; i++) mdl[i] = dflt(i);
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R1", {31'b0, rsp_valid}, 32'h0);
      check(rst_req_o === 1'b0, "R1", {31'b0, rst_req_o}, 32'h0);

      // R1: defaults of every index (28..31 read zero, R8 too)
      for (int i = 0; i < 32; i++) op(1'b0, i, 32'h0, "R1");

      // R2: plain words
      op(1'b1, 5, 32'hDEAD_BEEF, "R2");
      op(1'b0, 5, 32'h0, "R2");
      op(1'b1, 27, 32'h0000_0001, "R2");
      op(1'b0, 27, 32'h0, "R2");

      // R3 / R4: set and clear aliases
      op(1'b1, 12, 32'h0000_00F0, "R3");
      op(1'b0, 14, 32'h0, "R3");
      op(1'b1, 12, 32'h8000_000F, "R3");
      op(1'b0, 14, 32'h0, "R3");
      op(1'b0, 12, 32'h0, "R3");
      op(1'b1, 13, 32'h0000_0030, "R4");
      op(1'b0, 14, 32'h0, "R4");
      op(1'b0, 13, 32'h0, "R4");
      op(1'b1, 13, 32'hFFFF_FFFF, "R4");
      op(1'b0, 14, 32'h0, "R4");

      // R5: read-only words
      op(1'b1, 12, 32'h0000_0A0A, "R5");
      op(1'b1, 14, 32'hFFFF_FFFF, "R5");
      op(1'b0, 14, 32'h0, "R5");
      op(1'b1, 15, 32'h1234_5678, "R5");
      op(1'b0, 15, 32'h0, "R5");

      // R8: unmapped
      op(1'b1, 29, 32'hFFFF_FFFF, "R8");
      op(1'b0, 29, 32'h0, "R8");

      // R6 / R7: self-reset edge (default bit 2 = 1)
      op(1'b1, 1, 32'h0000_0004, "R7");
      op(1'b1, 1, 32'h0000_0000, "R7");
      op(1'b1, 1, 32'h0000_1384, "R6");
      @(negedge clk);
      check(rst_req_o === 1'b0, "R6", {31'b0, rst_req_o}, 32'h0);
      op(1'b0, 1, 32'h0, "R6");
      op(1'b1, 1, 32'h0000_0003, "R7");
      op(1'b1, 2, 32'h0000_0004, "R7");
      op(1'b0, 1, 32'h0, "R7");

      // random traffic over all indices
      for (int k = 0; k < 400; k++) begin
         int  idx;
         bit  wr;
         idx = int'($urandom_range(31, 0));
         if (k % 7 == 0) idx = 1;
         wr  = ($urandom_range(1, 0) == 1);
         r   = $urandom;
         op(wr, idx, r, "");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule